// File: doc/BRIEF.md
# Multi-format serial audio receiver

The receiver takes two-channel serial audio carried on a bit clock, a word clock and a data line. All three are sampled in a faster system clock domain. It decodes one of seven frame layouts, chosen by a 3-bit format code. These cover data justified to the end of the half-frame (16, 20 or 24 bits), data justified to its start (24 bits), and I2S framing with a one-bit delay (24 bits, or 16 bits in short frames). For each frame it presents one left/right pair, sign-extended to 24 bits, together with a one-cycle valid strobe.

Each half-frame is counted in bit clocks and compared with a minimum that depends on the format code. A bypass input raises that minimum to 32 bit clocks per half-frame, which is 64 per sample period. A half-frame that is too short is dropped and sets a sticky error flag. The format code and the bypass input are taken only while the active-low power-down input is held low. Changes made while the block is running are ignored. Code 7 is reserved: it silences the outputs and raises a format error.

Top module: `audio_fmt_rx`

## Requirements
- R1: Data is sampled on rising edges of `sck` and is MSB first, in two's complement. A pair is published when the right half-frame is closed by the next word-clock transition. `pair_valid` is high for exactly one system clock, and `left_out`/`right_out` change only together with that pulse. In the justified codes, `ws` high marks the left channel.
- R2: Code 0 takes the last 16 bits of each half-frame, sign-extended to 24 bits. It needs at least 16 bit clocks per half-frame.
- R3: Code 1 takes the last 20 bits of each half-frame, sign-extended. It needs at least 20 bit clocks per half-frame.
- R4: Code 4 takes the last 24 bits of each half-frame. It needs at least 24 bit clocks per half-frame.
- R5: Codes 2 and 5 take the first 24 bits after the word-clock edge. They need at least 24 bit clocks per half-frame.
- R6: Codes 3 and 6 use I2S framing: the MSB comes one bit clock after the `ws` edge, and `ws` low means left. Code 6 takes 24 bits and needs at least 24 bit clocks per half-frame. Code 3 takes 24 bits when the half-frame has 24 or more bit clocks. Otherwise it takes 16 bits, sign-extended, and it needs at least 16.
- R7: A half-frame shorter than its minimum is dropped, so its pair produces no `pair_valid`. It sets `short_err`, which stays high until power-down.
- R8: With code 7, `fmt_err` is high, `left_out` and `right_out` stay zero, and `pair_valid` never asserts.
- R9: `fmt_code` and `bypass` are captured while `pdn_n` is low and held while it is high. `pdn_n` low clears the outputs, the flags and the frame state.
- R10: With `bypass` captured high, every format needs at least 32 bit clocks per half-frame.
- R11: After reset the outputs are zero and `pair_valid`, `short_err` and `fmt_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Power-down, active low; format is captured while low |
| fmt_code | input | 3 | Frame format code |
| bypass | input | 1 | Raises the minimum half-frame length to 32 bit clocks |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word (channel) clock |
| sd | input | 1 | Serial data |
| left_out | output | 24 | Left sample, sign-extended |
| right_out | output | 24 | Right sample, sign-extended |
| pair_valid | output | 1 | One-cycle strobe for a new pair |
| short_err | output | 1 | Sticky flag for a half-frame that was too short |
| fmt_err | output | 1 | Reserved format code selected |

## Verification
The bench builds the block with its default two-stage synchronizer and a 6-bit bit counter. With these values, half-frames of 16 to 32 bit clocks fit comfortably inside a bit period of eight system clocks. The counter range reaches both the exact-minimum boundary of every format and the 32-clock bypass limit. Justified and I2S streams are produced from a single bit list: the word clock is shifted one bit early for I2S. This lets the same expected pairs exercise both polarities and both alignments.

// File: rtl/audio_fmt_rx.sv
module audio_fmt_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pdn_n,
  input  logic [2:0]  fmt_code,
  input  logic        bypass,
  input  logic        sck,
  input  logic        ws,
  input  logic        sd,
  output logic [23:0] left_out,
  output logic [23:0] right_out,
  output logic        pair_valid,
  output logic        short_err,
  output logic        fmt_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] N16 = CNT_W'(16);
  localparam logic [CNT_W-1:0] N20 = CNT_W'(20);
  localparam logic [CNT_W-1:0] N24 = CNT_W'(24);
  localparam logic [CNT_W-1:0] N32 = CNT_W'(32);

  logic [SYNC_STAGES:0] sck_sr, ws_sr, sd_sr;
  logic [2:0]       fmt_q;
  logic             byp_q, ws_last, half_ws, active, partial, left_ok;
  logic [CNT_W-1:0] cnt, min_half, word_n, msb_shift;
  logic [23:0]      msb_sr, lsb_sr, left_hold, raw_word, fin_word;

  wire sck_rise = sck_sr[SYNC_STAGES-1] & ~sck_sr[SYNC_STAGES];
  wire ws_s     = ws_sr[SYNC_STAGES-1];
  wire sd_s     = sd_sr[SYNC_STAGES-1];
  wire is_i2s   = (fmt_q == 3'd3) || (fmt_q == 3'd6);
  wire is_lsb   = (fmt_q == 3'd0) || (fmt_q == 3'd1) || (fmt_q == 3'd4);
  wire reserved = (fmt_q == 3'd7);
  wire eff_ws   = is_i2s ? ws_last : ws_s;
  wire fin_left = (half_ws == ~is_i2s);
  wire boundary = active && (eff_ws != half_ws);
  wire fin_short = cnt < min_half;

  assign fmt_err = pdn_n & reserved;

  always_comb begin
    case (fmt_q)
      3'd0:    word_n = N16;
      3'd1:    word_n = N20;
      3'd3:    word_n = (cnt >= N24) ? N24 : N16;
      default: word_n = N24;
    endcase
    if (byp_q)                                 min_half = N32;
    else if (fmt_q == 3'd0 || fmt_q == 3'd3)   min_half = N16;
    else if (fmt_q == 3'd1)                    min_half = N20;
    else                                       min_half = N24;
  end

  always_comb begin
    msb_shift = (cnt >= N16) ? cnt - N16 : '0;
    if (is_lsb)             raw_word = lsb_sr;
    else if (word_n == N24) raw_word = msb_sr;
    else                    raw_word = msb_sr >> msb_shift;
    case (word_n)
      N16:     fin_word = {{8{raw_word[15]}}, raw_word[15:0]};
      N20:     fin_word = {{4{raw_word[19]}}, raw_word[19:0]};
      default: fin_word = raw_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr <= '0; ws_sr <= '0; sd_sr <= '0;
    end else begin
      sck_sr <= {sck_sr[SYNC_STAGES-1:0], sck};
      ws_sr  <= {ws_sr[SYNC_STAGES-1:0], ws};
      sd_sr  <= {sd_sr[SYNC_STAGES-1:0], sd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0; byp_q <= 1'b0; ws_last <= 1'b0; half_ws <= 1'b0;
      active <= 1'b0; partial <= 1'b0; left_ok <= 1'b0; cnt <= '0;
      msb_sr <= '0; lsb_sr <= '0; left_hold <= '0;
      left_out <= '0; right_out <= '0; pair_valid <= 1'b0; short_err <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (!pdn_n) begin
        fmt_q <= fmt_code; byp_q <= bypass;
        ws_last <= 1'b0; active <= 1'b0; partial <= 1'b0; left_ok <= 1'b0;
        cnt <= '0; left_out <= '0; right_out <= '0; short_err <= 1'b0;
      end else if (reserved) begin
        left_out <= '0; right_out <= '0;
      end else if (sck_rise) begin
        ws_last <= ws_s;
        if (!active || boundary) begin
          if (active && !partial) begin
            if (fin_short) begin
              short_err <= 1'b1;
              left_ok   <= 1'b0;
            end else if (fin_left) begin
              left_hold <= fin_word;
              left_ok   <= 1'b1;
            end else if (left_ok) begin
              left_out   <= left_hold;
              right_out  <= fin_word;
              pair_valid <= 1'b1;
              left_ok    <= 1'b0;
            end
          end
          partial <= !active;
          active  <= 1'b1;
          half_ws <= eff_ws;
          cnt     <= CNT_W'(1);
          msb_sr  <= {23'd0, sd_s};
          lsb_sr  <= {23'd0, sd_s};
        end else begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (cnt < N24) msb_sr <= {msb_sr[22:0], sd_s};
          lsb_sr <= {lsb_sr[22:0], sd_s};
        end
      end
    end
  end
endmodule

// File: rtl/audio_fmt_rx_chk.sv
module audio_fmt_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pdn_n,
  input logic [2:0]  fmt_q,
  input logic [23:0] left_out,
  input logic [23:0] right_out,
  input logic        pair_valid,
  input logic        short_err,
  input logic        fmt_err
);
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pdn_n) && !$stable(left_out)) |-> pair_valid); // R1
  AST_SEXT16: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && fmt_q == 3'd0) |-> (left_out[23:16] == {8{left_out[15]}} && right_out[23:16] == {8{right_out[15]}})); // R2
  AST_SEXT20: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && fmt_q == 3'd1) |-> (left_out[23:20] == {4{left_out[19]}} && right_out[23:20] == {4{right_out[19]}})); // R3
  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (short_err && pdn_n) |=> short_err); // R7
  AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> (!pair_valid && left_out == 24'd0 && right_out == 24'd0)); // R8
  AST_PDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |=> (!pair_valid && !short_err && left_out == 24'd0 && right_out == 24'd0)); // R9
endmodule

bind audio_fmt_rx audio_fmt_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .fmt_q(fmt_q),
  .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid),
  .short_err(short_err), .fmt_err(fmt_err)
);

// File: tb/audio_fmt_rx_tb.sv
module audio_fmt_rx_tb_top;
  logic clk = 0, rst_n = 0, pdn_n = 0, bypass = 0, sck = 0, ws = 0, sd = 0;
  logic [2:0]  fmt_code = 0;
  logic [23:0] left_out, right_out;
  logic        pair_valid, short_err, fmt_err;

  audio_fmt_rx dut_i (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  logic [47:0] exp_q[$];
  logic ws_bits[$], sd_bits[$];
  logic [47:0] mon_e;
  logic prev_pv = 0;

  task automatic chk(bit ok, string req, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pair_valid) begin
      chk(!prev_pv, "R1", "pulse longer than one cycle", 48'(prev_pv), 48'd0);
      if (exp_q.size() == 0) chk(0, cur_req, "unexpected pair", {left_out, right_out}, 48'd0);
      else begin
        mon_e = exp_q.pop_front();
        chk({left_out, right_out} == mon_e, cur_req, "pair value", {left_out, right_out}, mon_e);
      end
    end
    prev_pv <= pair_valid;
  end

  function automatic int wlen(logic [2:0] code, int h);
    if (code == 0) return 16;
    if (code == 1) return 20;
    if (code == 3) return (h >= 24) ? 24 : 16;
    return 24;
  endfunction

  function automatic logic [23:0] sext(logic [23:0] v, int n);
    if (n == 16) return {{8{v[15]}}, v[15:0]};
    if (n == 20) return {{4{v[19]}}, v[19:0]};
    return v;
  endfunction

  function automatic logic left_lvl(logic [2:0] code);
    return !(code == 3 || code == 6);
  endfunction

  task automatic add_half(logic w, int h, logic [2:0] code, logic [23:0] v);
    int n = wlen(code, h);
    bit lsb = (code == 0 || code == 1 || code == 4);
    for (int p = 0; p < h; p++) begin
      int idx = lsb ? p - (h - n) : p;
      ws_bits.push_back(w);
      sd_bits.push_back((idx >= 0 && idx < n) ? v[n-1-idx] : 1'b0);
    end
  endtask

  task automatic send_bit(logic w, logic d);
    @(negedge clk); sck = 0; ws = w; sd = d;
    repeat (4) @(negedge clk);
    sck = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic flush(logic [2:0] code);
    bit i2s = (code == 3 || code == 6);
    for (int i = 0; i < ws_bits.size(); i++)
      send_bit((i2s && i + 1 < ws_bits.size()) ? ws_bits[i+1] : ws_bits[i], sd_bits[i]);
    ws_bits.delete(); sd_bits.delete();
  endtask

  task automatic start(logic [2:0] code, logic byp, string req);
    cur_req = req;
    @(negedge clk); pdn_n = 0; fmt_code = code; bypass = byp;
    repeat (6) @(negedge clk);
    pdn_n = 1;
    repeat (2) @(negedge clk);
    add_half(!left_lvl(code), 32, code, 24'd0);
  endtask

  task automatic frame(logic [2:0] code, int h, logic [23:0] l, logic [23:0] r, bit ok);
    add_half(left_lvl(code), h, code, l);
    add_half(!left_lvl(code), h, code, r);
    if (ok) exp_q.push_back({sext(l, wlen(code, h)), sext(r, wlen(code, h))});
  endtask

  task automatic finish_stream(logic [2:0] code);
    add_half(left_lvl(code), 4, code, 24'd0);
    flush(code);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, cur_req, "missing pairs", 48'(exp_q.size()), 48'd0);
    exp_q.delete();
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(left_out == 0 && right_out == 0, "R11", "outputs after reset", {left_out, right_out}, 48'd0);
    chk(!pair_valid && !short_err && !fmt_err, "R11", "flags after reset", {pair_valid, short_err, fmt_err}, 48'd0);

    // R2 code 0, 16-bit end-justified, minimum 16
    start(0, 0, "R2");
    frame(0, 16, 24'h001234, 24'h008001, 1);
    frame(0, 32, 24'h00FFFF, 24'h007FFF, 1);
    finish_stream(0);
    chk(!short_err, "R2", "no short flag at 16 clocks", 48'(short_err), 48'd0);

    // R3 code 1
    start(1, 0, "R3");
    frame(1, 20, 24'h080000, 24'h07FFFF, 1);
    frame(1, 32, 24'h0ABCDE, 24'h012345, 1);
    finish_stream(1);

    // R4 code 4
    start(4, 0, "R4");
    frame(4, 24, 24'h800000, 24'h123456, 1);
    frame(4, 32, 24'h7FFFFF, 24'hFEDCBA, 1);
    finish_stream(4);

    // R5 codes 2 and 5, start-justified
    start(2, 0, "R5");
    frame(2, 24, 24'hA5A5A5, 24'h5A5A5A, 1);
    finish_stream(2);
    start(5, 0, "R5");
    frame(5, 32, 24'h800001, 24'h00FF00, 1);
    finish_stream(5);

    // R6 I2S codes 6 and 3
    start(6, 0, "R6");
    frame(6, 24, 24'hC0FFEE, 24'h0BEEF0, 1);
    frame(6, 32, 24'h112233, 24'h998877, 1);
    finish_stream(6);
    start(3, 0, "R6");
    frame(3, 16, 24'h00F00D, 24'h000123, 1);
    frame(3, 32, 24'h876543, 24'h345678, 1);
    finish_stream(3);
    chk(!short_err, "R6", "16-clock I2S half accepted", 48'(short_err), 48'd0);

    // R7 short half-frame
    start(1, 0, "R7");
    frame(1, 19, 24'h011111, 24'h022222, 0);
    frame(1, 20, 24'h033333, 24'h044444, 1);
    finish_stream(1);
    chk(short_err, "R7", "short flag set", 48'(short_err), 48'd1);
    // R9 power-down clears flags and outputs
    @(negedge clk); pdn_n = 0;
    repeat (3) @(negedge clk);
    chk(!short_err, "R9", "short flag cleared by power-down", 48'(short_err), 48'd0);
    chk(left_out == 0 && right_out == 0, "R9", "outputs cleared by power-down", {left_out, right_out}, 48'd0);

    // R8 reserved code
    start(7, 0, "R8");
    chk(fmt_err, "R8", "format error raised", 48'(fmt_err), 48'd1);
    frame(7, 24, 24'h123456, 24'h654321, 0);
    finish_stream(7);
    chk(left_out == 0 && right_out == 0, "R8", "outputs silent", {left_out, right_out}, 48'd0);

    // R9 format change while running is ignored
    start(0, 0, "R9");
    fmt_code = 5;
    frame(0, 16, 24'h00ABCD, 24'h001357, 1);
    finish_stream(0);
    chk(!fmt_err && !short_err, "R9", "no flags after late code change", {short_err, fmt_err}, 48'd0);

    // R10 bypass minimum of 32
    start(5, 1, "R10");
    frame(5, 24, 24'h111111, 24'h222222, 0);
    frame(5, 32, 24'h333333, 24'h444444, 1);
    finish_stream(5);
    chk(short_err, "R10", "24-clock half short in bypass", 48'(short_err), 48'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule